// File: doc/BRIEF.md
# Integer Execution Unit with Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. It takes two operand words, a unit selector, an adder operation, a logic operation, a shift amount and a condition selector, and produces a result word, a result-valid strobe, a single condition bit and an illegal-operation indication. It holds no state: every output is a pure function of the present inputs.

The adder is evaluated on every input pattern, whatever unit is selected, so the overflow, carry and greater-than flags always describe the adder's view of the operands. The result word is taken from one of four units: the adder, a bitwise logic unit, a funnel shifter over both operands, or a leading-one priority encoder. A separate selector routes one adder flag, or a constant true, to the condition output. A no-operation selection drops result-valid, and unknown unit or logic codes are flagged rather than silently producing data.

Top module: `eu_exec`

## Requirements
- R1: Unit code 0 (no operation) drives result_valid low and result to zero; unit codes 1 (adder), 2 (logic), 3 (shifter) and 4 (priority encoder) drive result_valid high.
- R2: add_op bit 3 selects inversion of op_a and bit 0 supplies the carry-in; bits 2:1 are ignored. Code 0 gives op_a+op_b, 1 gives op_a+op_b+1, 8 gives NOT(op_a)+op_b, 9 gives NOT(op_a)+op_b+1, all modulo 2^32, and unit code 1 returns that sum.
- R3: Overflow is true when the (possibly inverted) first adder input and op_b share a sign bit and the sum's sign bit differs from it.
- R4: Carry is the carry out of bit 31 of the adder, including the carry-in.
- R5: Greater-than equals carry when the sign bits of the (possibly inverted) first adder input and op_b differ, and equals bit 31 of the original op_a otherwise.
- R6: Under unit code 2, logic_op 0 gives AND, 1 XOR, 2 OR, 3 NOR, 4 NAND of the operands.
- R7: Under unit code 3, the result is the low 32 bits of the 64-bit word {op_b, op_a} (op_b in the upper half) shifted right by shamt (0 to 63), zero-filled.
- R8: Under unit code 4, the result is the bit index of the most significant set bit of op_a, or 32 when op_a is zero.
- R9: cond_sel 0 makes cond_out constantly 1; 1 selects overflow, 2 carry, 3 greater-than.
- R10: The flags, and so cond_out, depend only on the operands and add_op, whatever unit code is applied.
- R11: Unit codes 5 to 7, or unit code 2 with logic_op 5 to 7, drive illegal_op high, result to zero and result_valid low; illegal_op is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| unit_sel | input | 3 | Result source: 0 none, 1 adder, 2 logic, 3 shifter, 4 priority encoder |
| add_op | input | 4 | Adder control: bit 3 invert op_a, bit 0 carry-in |
| logic_op | input | 3 | Bitwise function for the logic unit |
| shamt | input | 6 | Right shift distance for the funnel shifter |
| cond_sel | input | 2 | Condition source: 0 true, 1 overflow, 2 carry, 3 greater-than |
| result | output | 32 | Selected unit output |
| result_valid | output | 1 | High when a legal unit produced the result |
| cond_out | output | 1 | Selected condition flag |
| illegal_op | output | 1 | High for an unknown unit or logic code |

## Verification
The checks are immediate assertions evaluated whenever the inputs change, so they take for granted that every input is a settled, known value, with no X or Z bits on the operand or control buses. The bench drives every input from a defined value at time zero and changes them all together at a falling clock edge, sampling one time unit later, so no assertion sees a half-updated input set.

// File: rtl/eu_pkg.sv
package eu_pkg;

    typedef enum logic [2:0] {
        UNIT_NONE  = 3'd0,
        UNIT_ADD   = 3'd1,
        UNIT_LOGIC = 3'd2,
        UNIT_SHIFT = 3'd3,
        UNIT_PRIO  = 3'd4
    } unit_e;

    typedef enum logic [2:0] {
        LG_AND  = 3'd0,
        LG_XOR  = 3'd1,
        LG_OR   = 3'd2,
        LG_NOR  = 3'd3,
        LG_NAND = 3'd4
    } logic_e;

    typedef enum logic [1:0] {
        CS_TRUE  = 2'd0,
        CS_OVF   = 2'd1,
        CS_CARRY = 2'd2,
        CS_GT    = 2'd3
    } cond_e;

    localparam int ADD_INV_BIT = 3;
    localparam int ADD_CIN_BIT = 0;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic gt;
    } flags_t;

endpackage

// File: rtl/eu_adder.sv
module eu_adder
    import eu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] d1,
    input  logic [WIDTH-1:0] d2,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] sum,
    output flags_t           flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] in1;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        in1  = op[ADD_INV_BIT] ? ~d1 : d1;
        cin  = op[ADD_CIN_BIT];
        wide = {1'b0, in1} + {1'b0, d2} + {{WIDTH{1'b0}}, cin};
        sum  = wide[WIDTH-1:0];
    end

    always_comb begin
        flags.carry = wide[WIDTH];
        flags.ovf   = (in1[MSB] == d2[MSB]) && (wide[MSB] != in1[MSB]);
        if (in1[MSB] != d2[MSB])
            flags.gt = wide[WIDTH];
        else
            flags.gt = d1[MSB];
    end

endmodule

// File: rtl/eu_logic.sv
module eu_logic
    import eu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] d1,
    input  logic [WIDTH-1:0] d2,
    input  logic [2:0]       fn,
    output logic [WIDTH-1:0] res,
    output logic             bad_fn
);
    always_comb begin
        res    = '0;
        bad_fn = 1'b0;
        case (fn)
            LG_AND:  res = d1 & d2;
            LG_XOR:  res = d1 ^ d2;
            LG_OR:   res = d1 | d2;
            LG_NOR:  res = ~(d1 | d2);
            LG_NAND: res = ~(d1 & d2);
            default: bad_fn = 1'b1;
        endcase
    end

endmodule

// File: rtl/eu_funnel.sv
module eu_funnel #(
    parameter int WIDTH = 32,
    localparam int SW   = $clog2(2 * WIDTH)
) (
    input  logic [WIDTH-1:0] lo,
    input  logic [WIDTH-1:0] hi,
    input  logic [SW-1:0]    amt,
    output logic [WIDTH-1:0] res
);
    logic [2*WIDTH-1:0] joined;
    logic [2*WIDTH-1:0] moved;

    always_comb begin
        joined = {hi, lo};
        moved  = joined >> amt;
        res    = moved[WIDTH-1:0];
    end

endmodule

// File: rtl/eu_prio.sv
module eu_prio #(
    parameter int WIDTH  = 32,
    localparam int NBYTE = WIDTH / 8,
    localparam int PW    = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] din,
    output logic [PW-1:0]    idx
);
    logic [NBYTE-1:0] byte_hit;
    logic [2:0]       byte_pos [NBYTE];

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        logic [7:0] seg;
        assign seg         = din[8*g +: 8];
        assign byte_hit[g] = |seg;
        always_comb begin
            byte_pos[g] = 3'd0;
            for (int i = 0; i < 8; i++) begin
                if (seg[i]) byte_pos[g] = 3'(i);
            end
        end
    end

    always_comb begin
        idx = PW'(WIDTH);
        for (int g = 0; g < NBYTE; g++) begin
            if (byte_hit[g]) idx = PW'(g * 8) + PW'(byte_pos[g]);
        end
    end

endmodule

// File: rtl/eu_exec.sv
module eu_exec
    import eu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SW   = $clog2(2 * WIDTH),
    localparam int PW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       unit_sel,
    input  logic [3:0]       add_op,
    input  logic [2:0]       logic_op,
    input  logic [SW-1:0]    shamt,
    input  logic [1:0]       cond_sel,
    output logic [WIDTH-1:0] result,
    output logic             result_valid,
    output logic             cond_out,
    output logic             illegal_op
);
    logic [WIDTH-1:0] add_res;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] sh_res;
    logic [PW-1:0]    pr_idx;
    logic             lg_bad;
    flags_t           flg;

    eu_adder #(.WIDTH(WIDTH)) u_add (
        .d1(op_a), .d2(op_b), .op(add_op), .sum(add_res), .flags(flg)
    );

    eu_logic #(.WIDTH(WIDTH)) u_lg (
        .d1(op_a), .d2(op_b), .fn(logic_op), .res(lg_res), .bad_fn(lg_bad)
    );

    eu_funnel #(.WIDTH(WIDTH)) u_sh (
        .lo(op_a), .hi(op_b), .amt(shamt), .res(sh_res)
    );

    eu_prio #(.WIDTH(WIDTH)) u_pr (
        .din(op_a), .idx(pr_idx)
    );

    // Result steering
    always_comb begin
        result       = '0;
        result_valid = 1'b0;
        illegal_op   = 1'b0;
        case (unit_sel)
            UNIT_NONE: ;
            UNIT_ADD: begin
                result       = add_res;
                result_valid = 1'b1;
            end
            UNIT_LOGIC: begin
                if (lg_bad) begin
                    illegal_op = 1'b1;
                end else begin
                    result       = lg_res;
                    result_valid = 1'b1;
                end
            end
            UNIT_SHIFT: begin
                result       = sh_res;
                result_valid = 1'b1;
            end
            UNIT_PRIO: begin
                result       = {{(WIDTH-PW){1'b0}}, pr_idx};
                result_valid = 1'b1;
            end
            default: illegal_op = 1'b1;
        endcase
    end

    // Condition steering
    always_comb begin
        unique case (cond_sel)
            CS_TRUE:  cond_out = 1'b1;
            CS_OVF:   cond_out = flg.ovf;
            CS_CARRY: cond_out = flg.carry;
            CS_GT:    cond_out = flg.gt;
        endcase
    end

endmodule

// File: rtl/eu_exec_chk.sv
module eu_exec_chk #(
    parameter int WIDTH = 32,
    localparam int SW   = $clog2(2 * WIDTH)
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [2:0]       unit_sel,
    input logic [SW-1:0]    shamt,
    input logic [1:0]       cond_sel,
    input logic [WIDTH-1:0] result,
    input logic             result_valid,
    input logic             cond_out,
    input logic             illegal_op
);
    always_comb begin
        // R1: no-operation stays quiet
        if (unit_sel == 3'd0)
            p_nop_quiet_r1: assert (!result_valid && result == '0)
                else $error("nop produced data");
        // R11: illegal operation returns nothing
        if (illegal_op)
            p_illegal_zero_r11: assert (!result_valid && result == '0)
                else $error("illegal op produced data");
        // R11: high unit codes always flagged
        if (unit_sel > 3'd4)
            p_high_unit_r11: assert (illegal_op)
                else $error("unknown unit not flagged");
        // R9: constant-true condition
        if (cond_sel == 2'd0)
            p_cond_true_r9: assert (cond_out)
                else $error("true condition low");
        // R8: encoder output range
        if (unit_sel == 3'd4)
            p_prio_range_r8: assert (result <= WIDTH && (result == WIDTH) == (op_a == '0))
                else $error("priority index out of range");
        // R7: zero shift returns the low operand, full-width shift the high one
        if (unit_sel == 3'd3 && shamt == '0)
            p_shift_zero_r7: assert (result == op_a)
                else $error("zero shift altered operand");
        if (unit_sel == 3'd3 && shamt == SW'(WIDTH))
            p_shift_half_r7: assert (result == op_b)
                else $error("half shift wrong");
    end

endmodule

bind eu_exec eu_exec_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a(op_a), .op_b(op_b), .unit_sel(unit_sel), .shamt(shamt),
    .cond_sel(cond_sel), .result(result), .result_valid(result_valid),
    .cond_out(cond_out), .illegal_op(illegal_op)
);

// File: tb/tb_eu_exec.sv
`timescale 1ns/1ps
module tb_eu_exec;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  unit_sel = '0;
    logic [3:0]  add_op = '0;
    logic [2:0]  logic_op = '0;
    logic [5:0]  shamt = '0;
    logic [1:0]  cond_sel = '0;
    logic [31:0] result;
    logic        result_valid, cond_out, illegal_op;
    int tests = 0, failed = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eu_exec dut (
        .op_a(op_a), .op_b(op_b), .unit_sel(unit_sel), .add_op(add_op),
        .logic_op(logic_op), .shamt(shamt), .cond_sel(cond_sel),
        .result(result), .result_valid(result_valid), .cond_out(cond_out),
        .illegal_op(illegal_op)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flag model written from R2-R5 statements
    task automatic ref_flags(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                             output logic [31:0] s, output logic v, output logic c, output logic g);
        logic [32:0] t;
        logic [31:0] x;
        x = op[3] ? ~a : a;
        t = 33'(x) + 33'(b) + 33'(op[0]);
        s = t[31:0];
        c = t[32];
        v = (x[31] & b[31] & ~s[31]) | (~x[31] & ~b[31] & s[31]);
        g = (x[31] ^ b[31]) ? c : a[31];
    endtask

    function automatic logic [31:0] ref_prio(logic [31:0] a);
        for (int i = 31; i >= 0; i--) if (a[i]) return 32'(i);
        return 32'd32;
    endfunction

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] u, logic [3:0] ao,
                         logic [2:0] lo, logic [5:0] sh, logic [1:0] cs);
        @(negedge clk);
        op_a = a; op_b = b; unit_sel = u; add_op = ao;
        logic_op = lo; shamt = sh; cond_sel = cs;
        #1;
    endtask

    task automatic t_idle;   // R1 R9 initial values
        #1;
        chk("R1 idle valid", 32'(result_valid), 32'd0);
        chk("R1 idle result", result, 32'd0);
        chk("R9 idle cond", 32'(cond_out), 32'd1);
        chk("R11 idle illegal", 32'(illegal_op), 32'd0);
    endtask

    task automatic t_adder;  // R2 R3 R4 R5
        logic [31:0] av [6] = '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd5, 32'd5, 32'h8000_0000, 32'h1234_5678};
        logic [31:0] bv [6] = '{32'd1, 32'd1, 32'd3, 32'd3, 32'h8000_0000, 32'h0000_0010};
        logic [3:0]  ov [6] = '{4'd0, 4'd0, 4'd8, 4'd9, 4'd1, 4'd6};
        for (int k = 0; k < 6; k++) begin
            logic [31:0] s; logic v, c, g;
            ref_flags(av[k], bv[k], ov[k], s, v, c, g);
            apply(av[k], bv[k], 3'd1, ov[k], 3'd0, 6'd0, 2'd1);
            chk("R2 sum", result, s);
            chk("R1 add valid", 32'(result_valid), 32'd1);
            chk("R3 overflow", 32'(cond_out), 32'(v));
            apply(av[k], bv[k], 3'd1, ov[k], 3'd0, 6'd0, 2'd2);
            chk("R4 carry", 32'(cond_out), 32'(c));
            apply(av[k], bv[k], 3'd1, ov[k], 3'd0, 6'd0, 2'd3);
            chk("R5 gt", 32'(cond_out), 32'(g));
        end
        // explicit corners
        apply(32'h7FFF_FFFF, 32'd1, 3'd1, 4'd0, 3'd0, 6'd0, 2'd1);
        chk("R3 max positive overflow", 32'(cond_out), 32'd1);
        apply(32'hFFFF_FFFF, 32'd1, 3'd1, 4'd0, 3'd0, 6'd0, 2'd2);
        chk("R4 wrap carry", 32'(cond_out), 32'd1);
        chk("R2 wrap zero", result, 32'd0);
        apply(32'd5, 32'd3, 3'd1, 4'd9, 3'd0, 6'd0, 2'd0);
        chk("R2 reverse subtract", result, 32'hFFFF_FFFE);
    endtask

    task automatic t_flags_any_unit;  // R10
        logic [31:0] s; logic v, c, g;
        ref_flags(32'h7FFF_FFFF, 32'h0000_0001, 4'd0, s, v, c, g);
        for (int u = 0; u < 8; u++) begin
            apply(32'h7FFF_FFFF, 32'h0000_0001, 3'(u), 4'd0, 3'd0, 6'd4, 2'd1);
            chk("R10 overflow under any unit", 32'(cond_out), 32'(v));
        end
        apply(32'h0, 32'h0, 3'd0, 4'd8, 3'd0, 6'd0, 2'd3);
        chk("R10 gt with nop", 32'(cond_out), 32'd0);
        chk("R1 nop result", result, 32'd0);
        chk("R1 nop valid", 32'(result_valid), 32'd0);
    endtask

    task automatic t_logic;  // R6
        logic [31:0] a = 32'hF0F0_3C3C, b = 32'hFF00_0FF0;
        logic [31:0] ex [5];
        ex[0] = a & b; ex[1] = a ^ b; ex[2] = a | b; ex[3] = ~(a | b); ex[4] = ~(a & b);
        for (int f = 0; f < 5; f++) begin
            apply(a, b, 3'd2, 4'd0, 3'(f), 6'd0, 2'd0);
            chk("R6 logic function", result, ex[f]);
            chk("R6 logic valid", 32'(result_valid), 32'd1);
        end
    endtask

    task automatic t_shift;  // R7
        logic [31:0] a = 32'h89AB_CDEF, b = 32'h0123_4567;
        int amts [5] = '{0, 4, 31, 32, 63};
        for (int k = 0; k < 5; k++) begin
            logic [63:0] w;
            w = {b, a} >> amts[k];
            apply(a, b, 3'd3, 4'd0, 3'd0, 6'(amts[k]), 2'd0);
            chk("R7 funnel shift", result, w[31:0]);
        end
    endtask

    task automatic t_prio;  // R8
        logic [31:0] pats [6] = '{32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000, 32'h0000_0300, 32'h00F0_0001};
        for (int k = 0; k < 6; k++) begin
            apply(pats[k], 32'hFFFF_FFFF, 3'd4, 4'd0, 3'd0, 6'd0, 2'd0);
            chk("R8 priority index", result, ref_prio(pats[k]));
        end
    endtask

    task automatic t_illegal;  // R11
        for (int u = 5; u < 8; u++) begin
            apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'(u), 4'd0, 3'd0, 6'd0, 2'd0);
            chk("R11 unit illegal", 32'(illegal_op), 32'd1);
            chk("R11 unit result zero", result, 32'd0);
            chk("R11 unit valid low", 32'(result_valid), 32'd0);
        end
        for (int f = 5; f < 8; f++) begin
            apply(32'hFFFF_FFFF, 32'h1234_5678, 3'd2, 4'd0, 3'(f), 6'd0, 2'd0);
            chk("R11 logic illegal", 32'(illegal_op), 32'd1);
            chk("R11 logic result zero", result, 32'd0);
        end
        apply(32'hFFFF_FFFF, 32'h1234_5678, 3'd2, 4'd0, 3'd4, 6'd0, 2'd0);
        chk("R11 legal logic not flagged", 32'(illegal_op), 32'd0);
    endtask

    initial begin
        t_idle();
        t_adder();
        t_flags_any_unit();
        t_logic();
        t_shift();
        t_prio();
        t_illegal();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++;
            failed++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule